// File: doc/BRIEF.md
# Dual-Rate FSK Tag Waveform Generator

This block produces the baseband modulation stream that a 125 kHz proximity-tag emulator applies to its coil. Software or a controller loads a 44-bit identifier, split into a 12-bit upper part and a 32-bit lower part, and pulses a start strobe. From then on the block emits one modulation sample for each rising edge of a carrier-derived clock. A 1 leaves the coil open and a 0 shorts it. The stream repeats until a stop input is raised.

Each frame is built from two subcarrier cycle shapes. The short shape lasts 8 samples and the long shape lasts 10. A data half-bit is a group of short cycles or a group of long cycles, and the order of the two groups in a bit is what carries the data value, in Manchester fashion. Single short filler cycles mark the frame start and each nibble boundary. A start-of-frame marker is made of group combinations that cannot occur in valid Manchester data. The block builds the frame on the fly from a small set of nested counters. It does not play the frame out of a stored pattern.

The carrier input is a clean digital level that is not tied to the system clock. It passes through a synchronizer, and its rising edges are detected in the system clock domain. The frame length is a constant that the block exposes. The position of the next sample within the frame is also exposed.

Top module: `fsk_tag_wavegen`

## Requirements
- R1: A short cycle is 8 samples: 1,1 followed by six 0s. A long cycle is 10 samples: 1,1,1 followed by seven 0s.
- R2: A half-bit group is six short cycles (48 samples) or five long cycles (50 samples). A data 1 is a long group followed by a short group. A data 0 is a short group followed by a long group.
- R3: Every frame opens with one short filler cycle. Another short filler cycle comes before each run of four data bits, counted from the most significant bit, so there are 11 of them within the data.
- R4: The start-of-frame marker follows the opening filler. It is eight groups, in this order: short, short, short, long, long, long, short, long.
- R5: The 44 identifier bits are sent most significant first. Bits 43..32 are upper-part bits 11..0, and bits 31..0 are the lower-part bits.
- R6: A start with stop low and an upper part of at most 0xFFF is accepted. On the next clock the block latches the ID, sets active_o, clears sample_idx_o and err_o, and drives coil_o to 1. This applies even while the block is running. A start whose 32-bit upper part exceeds 0xFFF is rejected. On the next clock err_o is 1, and the running state, the position and the ID stay as they were.
- R7: One sample is emitted per rising edge of carrier_i. With two synchronizer stages, coil_o and sample_idx_o change on the third rising clock_i edge after carrier_i rises. Without a new carrier edge, both hold their values.
- R8: sample_idx_o gives the position of the next sample. After position 4799 is emitted it returns to 0, and the frame repeats with no gap.
- R9: frame_len_o is constantly 4800, which is 12 filler cycles of 8, plus 4×48 + 4×50 marker samples, plus 44×98 data samples.
- R10: When stop_i is high, on the next clock active_o is 0, coil_o is 1 and sample_idx_o is 0. A start in the same cycle has no effect.
- R11: While idle, coil_o stays 1 and carrier edges are ignored. sample_idx_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| carrier_i | input | 1 | Carrier-derived clock; one sample per rising edge |
| start_i | input | 1 | Start strobe; loads the ID and restarts the frame |
| stop_i | input | 1 | Returns the block to idle with the coil open |
| id_hi_i | input | 32 | Upper identifier part; only values up to 0xFFF are legal |
| id_lo_i | input | 32 | Lower 32 identifier bits |
| coil_o | output | 1 | Modulation sample: 1 open coil, 0 shorted coil |
| active_o | output | 1 | Frame playback running |
| err_o | output | 1 | Last start request was rejected |
| sample_idx_o | output | 13 | Position of the next sample in the frame |
| frame_len_o | output | 13 | Frame length in samples |

## Verification
The hardest point to reach from the ports is the wrap. That is the step from the last long or short cycle of bit 0 back to the opening filler, and it comes only after 4800 carrier edges. The bench gets there by playing complete frames for several identifiers and continuing past the wrap. It compares every sample against a frame that it builds itself from the cycle, group and marker rules. A rejected start in the middle of playback is issued with the stream running, and the bench then checks that the stream continues unchanged. A stop that coincides with a start is also exercised.

// File: rtl/fsk_gen_pkg.sv
package fsk_gen_pkg;

  typedef enum logic [1:0] {PH_OPEN, PH_SOF, PH_NIB, PH_DATA} phase_e;

  // short subcarrier cycle
  localparam int A_LEN  = 8;
  localparam int A_HIGH = 2;
  localparam int A_NCYC = 6;
  // long subcarrier cycle
  localparam int B_LEN  = 10;
  localparam int B_HIGH = 3;
  localparam int B_NCYC = 5;

  localparam int NIB_BITS   = 4;
  localparam int SOF_GROUPS = 8;
  // bit g set: marker group g uses long cycles
  localparam logic [SOF_GROUPS-1:0] SOF_PAT = 8'b1011_1000;

  localparam int POS_W = $clog2(B_LEN);
  localparam int CNT_W = $clog2(A_NCYC);
  localparam int GRP_W = $clog2(SOF_GROUPS);

  function automatic int frame_len(int id_bits);
    int fills, sof;
    fills = 1 + (id_bits + NIB_BITS - 1) / NIB_BITS;
    sof = 0;
    for (int g = 0; g < SOF_GROUPS; g++)
      sof += SOF_PAT[g] ? B_LEN * B_NCYC : A_LEN * A_NCYC;
    return fills * A_LEN + sof + id_bits * (A_LEN * A_NCYC + B_LEN * B_NCYC);
  endfunction

endpackage

// File: rtl/fsk_cycle_gen.sv
module fsk_cycle_gen
  import fsk_gen_pkg::*;
(
  input  logic             is_b_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             sample_o,
  output logic             cyc_end_o,
  output logic             grp_end_o
);

  localparam logic [POS_W-1:0] A_LAST = POS_W'(A_LEN - 1);
  localparam logic [POS_W-1:0] B_LAST = POS_W'(B_LEN - 1);
  localparam logic [POS_W-1:0] A_HI   = POS_W'(A_HIGH);
  localparam logic [POS_W-1:0] B_HI   = POS_W'(B_HIGH);
  localparam logic [CNT_W-1:0] A_CLST = CNT_W'(A_NCYC - 1);
  localparam logic [CNT_W-1:0] B_CLST = CNT_W'(B_NCYC - 1);

  always_comb begin
    if (is_b_i) begin
      sample_o  = pos_i < B_HI;
      cyc_end_o = pos_i == B_LAST;
      grp_end_o = cnt_i == B_CLST;
    end else begin
      sample_o  = pos_i < A_HI;
      cyc_end_o = pos_i == A_LAST;
      grp_end_o = cnt_i == A_CLST;
    end
  end

endmodule

// File: rtl/fsk_id_reg.sv
module fsk_id_reg #(
  parameter int ID_BITS   = 44,
  parameter int HI_BITS   = 12,
  parameter int HI_PORT_W = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       load_i,
  input  logic [HI_PORT_W-1:0]       hi_i,
  input  logic [ID_BITS-HI_BITS-1:0] lo_i,
  input  logic [$clog2(ID_BITS)-1:0] sel_i,
  output logic                       over_o,
  output logic                       bit_o
);

  localparam int BIT_W = $clog2(ID_BITS);
  localparam logic [BIT_W-1:0] MSB_IDX = BIT_W'(ID_BITS - 1);

  logic [ID_BITS-1:0] id_q;

  generate
    if (HI_PORT_W > HI_BITS) begin : g_range
      assign over_o = |hi_i[HI_PORT_W-1:HI_BITS];
    end else begin : g_fit
      assign over_o = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     id_q <= '0;
    else if (load_i) id_q <= {hi_i[HI_BITS-1:0], lo_i};
  end

  // sel counts from the most significant bit
  assign bit_o = id_q[MSB_IDX - sel_i];

endmodule

// File: rtl/fsk_frame_seq.sv
module fsk_frame_seq
  import fsk_gen_pkg::*;
#(
  parameter int ID_BITS = 44
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       restart_i,
  input  logic                       adv_i,
  input  logic                       id_bit_i,
  output logic [$clog2(ID_BITS)-1:0] bit_sel_o,
  output logic                       sample_o,
  output logic                       frame_end_o
);

  localparam int BIT_W = $clog2(ID_BITS);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(ID_BITS - 1);
  localparam logic [GRP_W-1:0] SOF_LAST = GRP_W'(SOF_GROUPS - 1);

  phase_e           phase_q;
  logic [POS_W-1:0] pos_q;
  logic [CNT_W-1:0] cnt_q;
  logic [GRP_W-1:0] grp_q;
  logic [BIT_W-1:0] bit_q;
  logic             is_b, cyc_end, grp_end, last_bit, nib_next;

  always_comb begin
    case (phase_q)
      PH_SOF:  is_b = SOF_PAT[grp_q];
      PH_DATA: is_b = id_bit_i ^ grp_q[0];
      default: is_b = 1'b0;
    endcase
  end

  fsk_cycle_gen u_cyc (
    .is_b_i    (is_b),
    .pos_i     (pos_q),
    .cnt_i     (cnt_q),
    .sample_o  (sample_o),
    .cyc_end_o (cyc_end),
    .grp_end_o (grp_end)
  );

  assign last_bit    = bit_q == BIT_LAST;
  assign nib_next    = ((32'(bit_q) + 1) % NIB_BITS) == 0;
  assign bit_sel_o   = bit_q;
  assign frame_end_o = adv_i && phase_q == PH_DATA && cyc_end && grp_end &&
                       grp_q[0] && last_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_OPEN;
      pos_q   <= '0;
      cnt_q   <= '0;
      grp_q   <= '0;
      bit_q   <= '0;
    end else if (restart_i) begin
      phase_q <= PH_OPEN;
      pos_q   <= '0;
      cnt_q   <= '0;
      grp_q   <= '0;
      bit_q   <= '0;
    end else if (adv_i) begin
      if (!cyc_end) begin
        pos_q <= pos_q + 1'b1;
      end else begin
        pos_q <= '0;
        case (phase_q)
          PH_OPEN: begin
            phase_q <= PH_SOF;
            cnt_q   <= '0;
            grp_q   <= '0;
          end
          PH_SOF: begin
            if (grp_end) begin
              cnt_q <= '0;
              if (grp_q == SOF_LAST) begin
                grp_q   <= '0;
                bit_q   <= '0;
                phase_q <= PH_NIB;
              end else begin
                grp_q <= grp_q + 1'b1;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          PH_NIB: begin
            phase_q <= PH_DATA;
            cnt_q   <= '0;
            grp_q   <= '0;
          end
          default: begin
            if (grp_end) begin
              cnt_q <= '0;
              if (!grp_q[0]) begin
                grp_q <= 1;
              end else begin
                grp_q <= '0;
                if (last_bit) begin
                  bit_q   <= '0;
                  phase_q <= PH_OPEN;
                end else begin
                  bit_q   <= bit_q + 1'b1;
                  phase_q <= nib_next ? PH_NIB : PH_DATA;
                end
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/fsk_tag_wavegen.sv
module fsk_tag_wavegen
  import fsk_gen_pkg::*;
#(
  parameter int ID_BITS     = 44,
  parameter int HI_BITS     = 12,
  parameter int HI_PORT_W   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                                      clk_i,
  input  logic                                      rst_ni,
  input  logic                                      carrier_i,
  input  logic                                      start_i,
  input  logic                                      stop_i,
  input  logic [HI_PORT_W-1:0]                      id_hi_i,
  input  logic [ID_BITS-HI_BITS-1:0]                id_lo_i,
  output logic                                      coil_o,
  output logic                                      active_o,
  output logic                                      err_o,
  output logic [$clog2(frame_len(ID_BITS)+1)-1:0]   sample_idx_o,
  output logic [$clog2(frame_len(ID_BITS)+1)-1:0]   frame_len_o
);

  localparam int FRAME_LEN = frame_len(ID_BITS);
  localparam int LEN_W     = $clog2(FRAME_LEN + 1);
  localparam int BIT_W     = $clog2(ID_BITS);
  localparam logic [LEN_W-1:0] IDX_LAST = LEN_W'(FRAME_LEN - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   edge_q, tick;
  logic                   over, accept, reject, restart, adv;
  logic                   id_bit, seq_sample, frame_end;
  logic [BIT_W-1:0]       bit_sel;
  logic                   active_q, err_q, coil_q;
  logic [LEN_W-1:0]       idx_q;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[i] <= 1'b0;
          else         sync_q[i] <= carrier_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[i] <= 1'b0;
          else         sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) edge_q <= 1'b0;
    else         edge_q <= sync_q[SYNC_STAGES-1];
  end

  assign tick    = sync_q[SYNC_STAGES-1] & ~edge_q;
  assign accept  = start_i & ~stop_i & ~over;
  assign reject  = start_i & ~stop_i & over;
  assign restart = stop_i | accept;
  assign adv     = tick & active_q & ~restart;

  fsk_id_reg #(
    .ID_BITS   (ID_BITS),
    .HI_BITS   (HI_BITS),
    .HI_PORT_W (HI_PORT_W)
  ) u_id (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .hi_i   (id_hi_i),
    .lo_i   (id_lo_i),
    .sel_i  (bit_sel),
    .over_o (over),
    .bit_o  (id_bit)
  );

  fsk_frame_seq #(
    .ID_BITS (ID_BITS)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .restart_i   (restart),
    .adv_i       (adv),
    .id_bit_i    (id_bit),
    .bit_sel_o   (bit_sel),
    .sample_o    (seq_sample),
    .frame_end_o (frame_end)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      err_q    <= 1'b0;
      coil_q   <= 1'b1;
      idx_q    <= '0;
    end else begin
      if (reject) err_q <= 1'b1;
      else if (accept) err_q <= 1'b0;

      if (restart) begin
        active_q <= ~stop_i;
        coil_q   <= 1'b1;
        idx_q    <= '0;
      end else if (adv) begin
        coil_q <= seq_sample;
        idx_q  <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
      end
    end
  end

  assign coil_o       = coil_q;
  assign active_o     = active_q;
  assign err_o        = err_q;
  assign sample_idx_o = idx_q;
  assign frame_len_o  = LEN_W'(FRAME_LEN);

endmodule

// File: rtl/fsk_gen_chk.sv
module fsk_gen_chk #(
  parameter int FRAME_LEN = 4800,
  parameter int LEN_W     = 13,
  parameter int HI_BITS   = 12,
  parameter int HI_PORT_W = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 start_i,
  input logic                 stop_i,
  input logic [HI_PORT_W-1:0] id_hi_i,
  input logic                 tick_i,
  input logic                 frame_end_i,
  input logic                 coil_o,
  input logic                 active_o,
  input logic                 err_o,
  input logic [LEN_W-1:0]     sample_idx_o
);

  logic hi_ok;
  assign hi_ok = (id_hi_i >> HI_BITS) == '0;

  a_r10_stop_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !active_o && coil_o && sample_idx_o == '0);

  a_r11_idle_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> coil_o && sample_idx_o == '0);

  a_r7_hold_no_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !start_i && !stop_i |=> $stable(coil_o) && $stable(sample_idx_o));

  a_r8_wrap_point: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_i |-> sample_idx_o == LEN_W'(FRAME_LEN - 1));

  a_r8_idx_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_idx_o < LEN_W'(FRAME_LEN));

  a_r6_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !stop_i && !hi_ok |=> err_o && $stable(active_o) && $stable(sample_idx_o));

  a_r6_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !stop_i && hi_ok |=> active_o && !err_o && coil_o && sample_idx_o == '0);

endmodule

bind fsk_tag_wavegen fsk_gen_chk #(
  .FRAME_LEN (FRAME_LEN),
  .LEN_W     (LEN_W),
  .HI_BITS   (HI_BITS),
  .HI_PORT_W (HI_PORT_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .stop_i       (stop_i),
  .id_hi_i      (id_hi_i),
  .tick_i       (tick),
  .frame_end_i  (frame_end),
  .coil_o       (coil_o),
  .active_o     (active_o),
  .err_o        (err_o),
  .sample_idx_o (sample_idx_o)
);

// File: tb/fsk_tag_wavegen_tb_top.sv
module fsk_tag_wavegen_tb_top;

  localparam int LEN = 4800;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        carrier_i = 1'b0;
  logic        start_i = 1'b0;
  logic        stop_i = 1'b0;
  logic [31:0] id_hi_i = '0;
  logic [31:0] id_lo_i = '0;
  logic        coil_o, active_o, err_o;
  logic [12:0] sample_idx_o, frame_len_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic exp_q [0:4999];
  int   exp_n;

  always #5 clk_i = ~clk_i;

  fsk_tag_wavegen dut_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .carrier_i    (carrier_i),
    .start_i      (start_i),
    .stop_i       (stop_i),
    .id_hi_i      (id_hi_i),
    .id_lo_i      (id_lo_i),
    .coil_o       (coil_o),
    .active_o     (active_o),
    .err_o        (err_o),
    .sample_idx_o (sample_idx_o),
    .frame_len_o  (frame_len_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one carrier period: three clocks high, three low
  task automatic tick();
    @(negedge clk_i) carrier_i = 1'b1;
    repeat (3) @(negedge clk_i);
    carrier_i = 1'b0;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic push_cyc(input bit long_c);
    int len, hi;
    len = long_c ? 10 : 8;
    hi  = long_c ? 3 : 2;
    for (int s = 0; s < len; s++) begin
      exp_q[exp_n] = (s < hi);
      exp_n++;
    end
  endtask

  task automatic push_grp(input bit long_c);
    for (int c = 0; c < (long_c ? 5 : 6); c++) push_cyc(long_c);
  endtask

  task automatic build(input logic [11:0] hi, input logic [31:0] lo);
    logic [43:0] id;
    bit   [7:0]  marker;
    id = {hi, lo};
    marker = {1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1}; // group 0 first
    exp_n = 0;
    push_cyc(1'b0);
    for (int g = 0; g < 8; g++) push_grp(marker[7-g]);
    for (int j = 0; j < 44; j++) begin
      if (j % 4 == 0) push_cyc(1'b0);
      push_grp(id[43-j]);
      push_grp(!id[43-j]);
    end
  endtask

  task automatic play(input int n, input int off, input string req);
    int bad = 0;
    for (int k = 0; k < n; k++) begin
      tick();
      if (coil_o !== exp_q[(off + k) % exp_n]) begin
        if (bad < 4)
          $display("FAIL %s sample %0d: actual %0b expected %0b", req,
                   (off + k) % exp_n, coil_o, exp_q[(off + k) % exp_n]);
        bad++;
      end
    end
    n_tests++;
    if (bad != 0) n_fail++;
  endtask

  task automatic start_id(input logic [31:0] hi, input logic [31:0] lo);
    @(negedge clk_i);
    id_hi_i = hi;
    id_lo_i = lo;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    n_tests++;
    n_fail++;
    $display("FAIL R7 watchdog expired: actual 1 expected 0");
    summary();
    $finish;
  end

  initial begin
    logic [12:0] idx0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // reset state and frame length
    chk(coil_o === 1'b1, "R11", "reset coil", coil_o, 1);
    chk(active_o === 1'b0, "R11", "reset active", active_o, 0);
    chk(err_o === 1'b0, "R6", "reset err", err_o, 0);
    chk(sample_idx_o === 13'd0, "R8", "reset idx", sample_idx_o, 0);
    chk(frame_len_o === 13'(LEN), "R9", "frame_len_o", frame_len_o, LEN);
    build(12'h000, 32'h0);
    chk(exp_n == 12*8 + 4*48 + 4*50 + 44*98, "R9", "bench frame size", exp_n,
        12*8 + 4*48 + 4*50 + 44*98);

    // idle ignores carrier
    for (int k = 0; k < 5; k++) tick();
    chk(coil_o === 1'b1 && sample_idx_o === 13'd0, "R11", "idle after edges",
        {coil_o, sample_idx_o}, {1'b1, 13'd0});

    // all-zero ID
    start_id(32'h0, 32'h0);
    chk(active_o === 1'b1 && sample_idx_o === 13'd0 && err_o === 1'b0, "R6",
        "accepted start", {active_o, err_o}, 2'b10);
    // R7 latency: third rising clock edge after the carrier rises
    @(negedge clk_i) carrier_i = 1'b1;
    idx0 = sample_idx_o;
    repeat (2) @(negedge clk_i);
    chk(sample_idx_o === idx0, "R7", "idx before third edge", sample_idx_o, idx0);
    @(negedge clk_i);
    chk(sample_idx_o === idx0 + 13'd1, "R7", "idx at third edge", sample_idx_o, idx0 + 1);
    carrier_i = 1'b0;
    repeat (3) @(negedge clk_i);
    repeat (4) @(negedge clk_i);
    chk(sample_idx_o === idx0 + 13'd1, "R7", "hold without edge", sample_idx_o, idx0 + 1);
    play(LEN - 1, 1, "R1 R2 R3 R4 R5 zero-ID frame");
    chk(sample_idx_o === 13'd0, "R8", "idx wraps to 0", sample_idx_o, 0);
    play(20, 0, "R8 R3 gapless repeat");

    // all-ones ID, restart while running
    build(12'hFFF, 32'hFFFF_FFFF);
    start_id(32'h0000_0FFF, 32'hFFFF_FFFF);
    chk(sample_idx_o === 13'd0 && active_o === 1'b1, "R6", "restart while running",
        sample_idx_o, 0);
    play(LEN, 0, "R1 R2 R3 R4 R5 ones-ID frame");

    // rejected start leaves stream unchanged
    start_id(32'h0000_1000, 32'h1234_5678);
    chk(err_o === 1'b1, "R6", "reject raises err", err_o, 1);
    chk(active_o === 1'b1 && sample_idx_o === 13'd0, "R6", "reject keeps position",
        sample_idx_o, 0);
    play(100, 0, "R6 stream after reject");

    // stop together with a legal start
    @(negedge clk_i);
    id_hi_i = 32'h0000_0123;
    stop_i  = 1'b1;
    start_i = 1'b1;
    @(negedge clk_i);
    stop_i  = 1'b0;
    start_i = 1'b0;
    chk(active_o === 1'b0 && coil_o === 1'b1 && sample_idx_o === 13'd0, "R10",
        "stop wins over start", {active_o, coil_o}, 2'b01);
    chk(err_o === 1'b1, "R10", "start ignored under stop", err_o, 1);
    for (int k = 0; k < 3; k++) tick();
    chk(coil_o === 1'b1 && sample_idx_o === 13'd0, "R11", "idle after stop",
        sample_idx_o, 0);

    // mixed ID, wrap continuation
    build(12'hA5C, 32'h3C96_E01B);
    start_id(32'h0000_0A5C, 32'h3C96_E01B);
    chk(err_o === 1'b0, "R6", "accept clears err", err_o, 0);
    play(LEN, 0, "R1 R2 R3 R4 R5 mixed-ID frame");
    play(200, 0, "R8 mixed-ID second frame");

    // stop mid-frame
    play(37, 200, "R5 mid-frame");
    @(negedge clk_i) stop_i = 1'b1;
    @(negedge clk_i) stop_i = 1'b0;
    chk(active_o === 1'b0 && coil_o === 1'b1 && sample_idx_o === 13'd0, "R10",
        "stop mid-frame", sample_idx_o, 0);
    for (int k = 0; k < 3; k++) tick();
    chk(coil_o === 1'b1, "R11", "coil open while idle", coil_o, 1);

    summary();
    $finish;
  end

endmodule